// File: doc/BRIEF.md
# Fixed-Priority Four-Port Bus Matrix

This block sits between four bus masters and four slave ports. The masters are an instruction-fetch port, a data port, a general system bus and a DMA engine. The slave ports are flash, ROM, SRAM and peripherals. Each master presents a request with an address. The block decodes which slave the address targets and checks whether that master may reach that slave under the current security inputs. When several permitted masters want the same slave, it gives the slave to one of them using a fixed ranking that belongs to that slave.

A denied request gets a one-cycle error pulse and is never granted. A granted master keeps its slave until it drops its request. Losing masters stay stalled, with their requests held, until the slave frees. Data paths, wait states and the memories themselves are outside the block. The block only produces per-master grant and error signals, and per-slave select and owner signals.

Top module: `bus_matrix`

## Requirements
- R1: The target slave is chosen by address bits [31:24]: 0x00 flash, 0x01 SRAM through its code-space alias, 0x02 ROM, 0x20 SRAM through its system-space alias, 0x40 peripherals. Any other value is unmapped and is answered with an error.
- R2: Permitted pairs are: the instruction port and the data port may reach flash, ROM and SRAM; the system bus may reach SRAM and peripherals; DMA may reach flash, SRAM and peripherals. Any other pair is answered with an error and never granted.
- R3: For flash, competing permitted requests are ranked DMA first, then the data port, then the instruction port.
- R4: For ROM, the data port wins over the instruction port.
- R5: For SRAM, the ranking is DMA, then the data port, then the system bus, then the instruction port.
- R6: For peripherals, DMA wins over the system bus.
- R7: A DMA request addressed through the SRAM code-space alias (0x01) is answered with an error.
- R8: When both secure_en and ip_prot_en are high, a DMA flash request with address bit 17 clear (bank 0) is answered with an error. With bit 17 set (bank 1), or with either input low, the request is allowed.
- R9: When secure_en is high, a data-port flash request is answered with an error.
- R10: m_grant rises one clock edge after a permitted request is first sampled. m_err is high in the cycle after each cycle in which a denied request is sampled, and low otherwise.
- R11: An owner keeps its slave while its request stays high, even when a higher-ranked master requests the same slave.
- R12: A stalled master receives the slave at the same edge at which the owner's request is sampled low. s_sel and s_owner then show the slave as selected and name the new owner.
- R13: While rst is high, and in the first cycle after it, all grants, errors and slave selects are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| secure_en | input | 1 | Secure mode: blocks data-port flash access and enables the DMA bank check |
| ip_prot_en | input | 1 | Together with secure_en, restricts DMA flash access to bank 1 |
| m_req | input | 4 | Request per master: bit 0 instruction, 1 data, 2 system bus, 3 DMA |
| m_addr | input | 128 | Address per master, master m in bits [32m+31:32m] |
| m_grant | output | 4 | Master currently owns its target slave |
| m_err | output | 4 | One-cycle error response per master |
| s_sel | output | 4 | Slave selected: bit 0 flash, 1 ROM, 2 SRAM, 3 peripherals |
| s_owner | output | 8 | Index of the owning master per slave, slave s in bits [2s+1:2s] |

## Verification
Two things can happen to the same slave in one cycle: arbitration among several requesters, and the rejection of one of those requesters by the permission or security checks. The vector table provokes this in several ways. It sends requests from masters that are banned from a slave, and from masters that secure mode blocks, to the same slave as permitted competitors. In each case the result is judged by checking two things together: the rejected master gets only an error, and the grant goes to the best-ranked master that remains permitted. A directed sequence then layers a higher-ranked late arrival on top of an existing owner. It checks that ownership neither moves early nor is lost at handoff.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int NM = 4;
  localparam int NS = 4;
  localparam int MW = 2;
  localparam int SW = 2;
  localparam int NO_ACCESS = 7;

  localparam int M_ICODE = 0;
  localparam int M_DCODE = 1;
  localparam int M_SBUS  = 2;
  localparam int M_DMA   = 3;

  localparam int S_FLASH  = 0;
  localparam int S_ROM    = 1;
  localparam int S_SRAM   = 2;
  localparam int S_PERIPH = 3;

  // rank 0 is the strongest; NO_ACCESS marks a forbidden pair
  function automatic int rank(input int s, input int m);
    int r;
    r = NO_ACCESS;
    case (s)
      S_FLASH:  case (m) M_DMA: r = 0; M_DCODE: r = 1; M_ICODE: r = 2; default: r = NO_ACCESS; endcase
      S_ROM:    case (m) M_DCODE: r = 0; M_ICODE: r = 1; default: r = NO_ACCESS; endcase
      S_SRAM:   case (m) M_DMA: r = 0; M_DCODE: r = 1; M_SBUS: r = 2; M_ICODE: r = 3; default: r = NO_ACCESS; endcase
      S_PERIPH: case (m) M_DMA: r = 0; M_SBUS: r = 1; default: r = NO_ACCESS; endcase
      default:  r = NO_ACCESS;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bm_port.sv
module bm_port
  import bm_pkg::*;
#(
  parameter int AW       = 32,
  parameter int BANK_BIT = 17,
  parameter int MID      = 0
) (
  input  logic [AW-1:0] addr,
  input  logic          secure_en,
  input  logic          ip_prot_en,
  output logic [SW-1:0] slv,
  output logic          ok
);
  localparam int TOP_LSB = AW - 8;

  logic [7:0] region;
  logic       hit;
  logic       code_alias;

  assign region = addr[AW-1:TOP_LSB];

  always_comb begin
    hit        = 1'b1;
    code_alias = 1'b0;
    slv        = SW'(S_FLASH);
    case (region)
      8'h00: slv = SW'(S_FLASH);
      8'h01: begin slv = SW'(S_SRAM); code_alias = 1'b1; end
      8'h02: slv = SW'(S_ROM);
      8'h20: slv = SW'(S_SRAM);
      8'h40: slv = SW'(S_PERIPH);
      default: hit = 1'b0;
    endcase
  end

  always_comb begin
    ok = hit && (rank(int'(slv), MID) != NO_ACCESS);
    if (MID == M_DMA && code_alias)
      ok = 1'b0;
    if (MID == M_DMA && slv == SW'(S_FLASH) && secure_en && ip_prot_en && !addr[BANK_BIT])
      ok = 1'b0;
    if (MID == M_DCODE && slv == SW'(S_FLASH) && secure_en)
      ok = 1'b0;
  end
endmodule

// File: rtl/bm_slave_arb.sv
module bm_slave_arb
  import bm_pkg::*;
#(
  parameter int SID = 0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NM-1:0]          m_req,
  input  logic [NM-1:0][SW-1:0]  m_tgt,
  input  logic [NM-1:0]          m_ok,
  output logic                   own_vld,
  output logic [MW-1:0]          own_idx
);
  logic [NM-1:0] want;
  logic          hold;
  logic          found;
  logic [MW-1:0] pick_idx;

  always_comb begin
    for (int m = 0; m < NM; m++)
      want[m] = m_req[m] && m_ok[m] && (m_tgt[m] == SW'(SID));
  end

  assign hold = own_vld && want[own_idx];

  always_comb begin
    found    = 1'b0;
    pick_idx = '0;
    for (int lvl = 0; lvl < NM; lvl++)
      for (int m = 0; m < NM; m++)
        if (!found && want[m] && rank(SID, m) == lvl) begin
          found    = 1'b1;
          pick_idx = MW'(m);
        end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_vld <= 1'b0;
      own_idx <= '0;
    end else if (!hold) begin
      own_vld <= found;
      own_idx <= pick_idx;
    end
  end

  // R11
  hold_owner_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> (own_vld && own_idx == $past(own_idx)));

  // R2
  owner_allowed_chk: assert property (@(posedge clk) disable iff (rst)
    own_vld |-> (rank(SID, int'(own_idx)) != NO_ACCESS));

  // R12
  handoff_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && (|want)) |=> own_vld);
endmodule

// File: rtl/bus_matrix.sv
module bus_matrix
  import bm_pkg::*;
#(
  parameter int AW       = 32,
  parameter int BANK_BIT = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             secure_en,
  input  logic             ip_prot_en,
  input  logic [NM-1:0]    m_req,
  input  logic [NM*AW-1:0] m_addr,
  output logic [NM-1:0]    m_grant,
  output logic [NM-1:0]    m_err,
  output logic [NS-1:0]    s_sel,
  output logic [NS*MW-1:0] s_owner
);
  logic [NM-1:0][SW-1:0] tgt;
  logic [NM-1:0]         ok;
  logic [NS-1:0]         vld;
  logic [NS-1:0][MW-1:0] idx;
  logic [NM-1:0][NS-1:0] hold_map;

  genvar gm, gs;
  generate
    for (gm = 0; gm < NM; gm++) begin : g_port
      bm_port #(.AW(AW), .BANK_BIT(BANK_BIT), .MID(gm)) u_port (
        .addr      (m_addr[gm*AW +: AW]),
        .secure_en (secure_en),
        .ip_prot_en(ip_prot_en),
        .slv       (tgt[gm]),
        .ok        (ok[gm])
      );
    end
    for (gs = 0; gs < NS; gs++) begin : g_arb
      bm_slave_arb #(.SID(gs)) u_arb (
        .clk    (clk),
        .rst    (rst),
        .m_req  (m_req),
        .m_tgt  (tgt),
        .m_ok   (ok),
        .own_vld(vld[gs]),
        .own_idx(idx[gs])
      );
      assign s_owner[gs*MW +: MW] = idx[gs];
    end
  endgenerate

  always_comb begin
    for (int m = 0; m < NM; m++)
      for (int s = 0; s < NS; s++)
        hold_map[m][s] = vld[s] && (idx[s] == MW'(m));
  end

  always_comb begin
    for (int m = 0; m < NM; m++)
      m_grant[m] = |hold_map[m];
  end

  assign s_sel = vld;

  always_ff @(posedge clk) begin
    if (rst) m_err <= '0;
    else     m_err <= m_req & ~ok;
  end

  generate
    for (gm = 0; gm < NM; gm++) begin : g_chk
      // R10
      err_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (m_req[gm] && !ok[gm]) |=> (m_err[gm] && !m_grant[gm]));
      // R2
      one_slave_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hold_map[gm]));
    end
  endgenerate
endmodule

// File: tb/bus_matrix_bench.sv
module bus_matrix_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;

  localparam logic [31:0] F0 = 32'h0000_1000;
  localparam logic [31:0] F1 = 32'h0002_0000;
  localparam logic [31:0] RM = 32'h0200_0400;
  localparam logic [31:0] SC = 32'h0100_0000;
  localparam logic [31:0] SS = 32'h2000_0000;
  localparam logic [31:0] PP = 32'h4000_0000;
  localparam logic [31:0] XX = 32'h1000_0000;

  // {req, addr dma, addr sys, addr data, addr instr, secure, ipprot, exp grant, exp err}
  localparam logic [141:0] VEC [NV] = '{
    {4'b1111, F0, F0, F0, F0, 1'b0, 1'b0, 4'b1000, 4'b0100}, // R3 R2
    {4'b0011, F0, F0, F0, F0, 1'b0, 1'b0, 4'b0010, 4'b0000}, // R3
    {4'b1111, RM, RM, RM, RM, 1'b0, 1'b0, 4'b0010, 4'b1100}, // R4 R2
    {4'b1111, SS, SS, SS, SC, 1'b0, 1'b0, 4'b1000, 4'b0000}, // R5
    {4'b0111, SS, SS, SC, SC, 1'b0, 1'b0, 4'b0010, 4'b0000}, // R5
    {4'b0101, SS, SS, SS, SS, 1'b0, 1'b0, 4'b0100, 4'b0000}, // R5
    {4'b1111, PP, PP, PP, PP, 1'b0, 1'b0, 4'b1000, 4'b0011}, // R6 R2
    {4'b0100, PP, PP, PP, PP, 1'b0, 1'b0, 4'b0100, 4'b0000}, // R6
    {4'b1001, SC, SS, SS, SC, 1'b0, 1'b0, 4'b0001, 4'b1000}, // R7
    {4'b1001, F0, SS, SS, F1, 1'b1, 1'b1, 4'b0001, 4'b1000}, // R8
    {4'b1000, F1, SS, SS, SS, 1'b1, 1'b1, 4'b1000, 4'b0000}, // R8
    {4'b1000, F0, SS, SS, SS, 1'b0, 1'b1, 4'b1000, 4'b0000}, // R8
    {4'b1011, F0, SS, F0, F0, 1'b1, 1'b0, 4'b1000, 4'b0010}, // R9 R8
    {4'b1111, XX, XX, XX, XX, 1'b0, 1'b0, 4'b0000, 4'b1111}, // R1
    {4'b0011, XX, XX, RM, XX, 1'b0, 1'b0, 4'b0010, 4'b0001}, // R1
    {4'b1111, SS, PP, F0, RM, 1'b0, 1'b0, 4'b1111, 4'b0000}  // R1 concurrent slaves
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         secure_en = 1'b0;
  logic         ip_prot_en = 1'b0;
  logic [3:0]   m_req = '0;
  logic [127:0] m_addr = '0;
  logic [3:0]   m_grant;
  logic [3:0]   m_err;
  logic [3:0]   s_sel;
  logic [7:0]   s_owner;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_matrix u_bus_matrix (
    .clk(clk), .rst(rst), .secure_en(secure_en), .ip_prot_en(ip_prot_en),
    .m_req(m_req), .m_addr(m_addr), .m_grant(m_grant), .m_err(m_err),
    .s_sel(s_sel), .s_owner(s_owner)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      wrap_up();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R13 grant in reset", {4'b0, m_grant}, 8'h00);
    check("R13 err in reset", {4'b0, m_err}, 8'h00);
    check("R13 sel in reset", {4'b0, s_sel}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    check("R13 sel after reset", {4'b0, s_sel}, 8'h00);

    for (int v = 0; v < NV; v++) begin
      m_req      = VEC[v][141:138];
      m_addr     = VEC[v][137:10];
      secure_en  = VEC[v][9];
      ip_prot_en = VEC[v][8];
      @(negedge clk);
      check($sformatf("R1-R9 vec %0d grant", v), {4'b0, m_grant}, {4'b0, VEC[v][7:4]});
      check($sformatf("R2 vec %0d err", v), {4'b0, m_err}, {4'b0, VEC[v][3:0]});
      m_req = '0;
      @(negedge clk);
    end
    secure_en  = 1'b0;
    ip_prot_en = 1'b0;

    // R10 grant latency, then R11 no pre-emption
    m_addr[31:0] = F0;
    m_req = 4'b0001;
    #1;
    check("R10 grant before edge", {4'b0, m_grant}, 8'h00);
    @(negedge clk);
    check("R10 grant after edge", {4'b0, m_grant}, 8'h01);
    m_addr[127:96] = F1;
    m_req = 4'b1001;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R11 owner kept", {4'b0, m_grant}, 8'h01);
      check("R11 owner index", {6'b0, s_owner[1:0]}, 8'h00);
    end
    // R12 handoff at release
    m_req = 4'b1000;
    @(negedge clk);
    check("R12 new grant", {4'b0, m_grant}, 8'h08);
    check("R12 flash selected", {7'b0, s_sel[0]}, 8'h01);
    check("R12 new owner", {6'b0, s_owner[1:0]}, 8'h03);
    m_req = '0;
    @(negedge clk);
    check("R12 released", {4'b0, s_sel}, 8'h00);

    // R10 error per sampled cycle
    m_addr[95:64] = F0;
    m_req = 4'b0100;
    @(negedge clk);
    check("R10 err first", {4'b0, m_err}, 8'h04);
    @(negedge clk);
    check("R10 err held", {4'b0, m_err}, 8'h04);
    check("R2 denied never granted", {4'b0, m_grant}, 8'h00);
    m_req = '0;
    @(negedge clk);
    check("R10 err cleared", {4'b0, m_err}, 8'h00);

    done = 1'b1;
    wrap_up();
  end
endmodule